// File: doc/BRIEF.md
# Duty-Cycle Current Share Encoder

This block lets several converters that run in parallel balance their load over a single open-drain share line. Each unit turns its local output-current code into a low-going pulse that repeats once per fixed period of system clocks. The pulse starts at the start of the period and its width is proportional to the current. A code equal to the nominal current holds the line low for 65 percent of the period. Because any unit can hold the line low, the line behaves as a wired-AND. The low time seen on the line is therefore the longest pulse of all units, which is the pulse of the most heavily loaded one.

The block also samples the line through a synchronizer and counts the low samples in each period. At every period boundary it converts that count back into a current code. It then reports the signed difference between that bus code and its own code. This difference is the share error that an outer loop can use to trim its setpoint. The difference saturates to the width of the error output. Sharing only applies above 20 percent of nominal load. Below that threshold the error is forced to zero.

Top module: `duty_share_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs_pull_o` is 0, `bus_code_o` is 0 and `share_err_o` is 0.
- R2: The period is PERIOD clocks long. At each period boundary the current code is latched. In the following period `cs_pull_o` is 1 for exactly L = min(floor(code*PERIOD*65/(100*NOM_CODE)), PERIOD) consecutive cycles, starting with the first cycle of the period.
- R3: A code equal to NOM_CODE gives a pulse of 65 percent of the period (130 of 200 clocks at default parameters). A code of 0 never pulls the line.
- R4: A code whose scaled width exceeds the period is clamped, so the line is held low for the whole period.
- R5: The line is sampled through SYNC_STAGES flip-flops. The number C of low samples in each period window is latched at the boundary and reported as `bus_code_o` = min(floor(C*100*NOM_CODE/(65*PERIOD)), 2^CODE_W-1). When several units share the line, this reflects the widest pulse.
- R6: `share_err_o` is the two's-complement value bus code minus local latched code, saturated to the range -2^(ERR_W-1) to 2^(ERR_W-1)-1.
- R7: When the local latched code is below NOM_CODE*20/100 (20 at defaults), `share_err_o` is 0 whatever the bus carries. A code of exactly that threshold is already active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_code_i | input | CODE_W | Local output-current code |
| cs_line_i | input | 1 | Sensed level of the shared open-drain line (0 = low) |
| cs_pull_o | output | 1 | 1 = pull the shared line low |
| bus_code_o | output | CODE_W | Current code recovered from the bus duty |
| share_err_o | output | ERR_W | Signed, saturated bus code minus local code |

## Verification
A new input code takes effect at the next period boundary. The recovered bus code updates on the clock edge that closes a period. The share error follows one cycle later. The synchronizer shifts the sampled window by SYNC_STAGES cycles, but this does not change the count in steady state. After each new stimulus the bench therefore waits three full periods so that every register on the path holds a settled value. It then measures the pulse width over exactly one period and compares the bus code and error on falling edges. Between stimuli the inputs are held constant.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int unsigned DUTY_PCT = 65;
    localparam int unsigned MIN_PCT  = 20;

    typedef enum logic {
        LINE_FREE = 1'b0,
        LINE_PULL = 1'b1
    } drive_e;

    // Scaled low time for a current code, clamped to the period.
    function automatic int unsigned code_to_len(int unsigned code,
                                                int unsigned period,
                                                int unsigned nom);
        int unsigned t;
        t = (code * period * DUTY_PCT) / (100 * nom);
        return (t > period) ? period : t;
    endfunction

    // Inverse mapping from a low count back to a code, clamped to max.
    function automatic int unsigned len_to_code(int unsigned cnt,
                                                int unsigned period,
                                                int unsigned nom,
                                                int unsigned maxc);
        int unsigned c;
        c = (cnt * 100 * nom) / (DUTY_PCT * period);
        return (c > maxc) ? maxc : c;
    endfunction

endpackage

// File: rtl/cs_phase_timer.sv
module cs_phase_timer #(
    parameter int unsigned PERIOD = 200,
    parameter int unsigned CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] phase_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] phase_q;

    assign wrap_o  = (phase_q == LAST);
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= '0;
        else if (wrap_o) phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (phase_o == '0)); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> (phase_o == $past(phase_o) + 1'b1)); // R2

endmodule

// File: rtl/cs_duty_enc.sv
module cs_duty_enc
    import cs_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned PERIOD   = 200,
    parameter int unsigned NOM_CODE = 100,
    parameter int unsigned CNT_W    = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    input  logic [CNT_W-1:0]  phase_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              pull_o
);
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  len_q;
    drive_e            drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            len_q  <= '0;
        end else if (wrap_i) begin
            code_q <= code_i;
            len_q  <= CNT_W'(code_to_len(32'(code_i), PERIOD, NOM_CODE));
        end
    end

    always_comb drv = (phase_i < len_q) ? LINE_PULL : LINE_FREE;

    assign pull_o = (drv == LINE_PULL);
    assign code_o = code_q;

    AST_PULSE_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_o) |-> (phase_i == '0)); // R2
    AST_ZERO_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0) |-> !pull_o); // R3

endmodule

// File: rtl/cs_bus_dec.sv
module cs_bus_dec
    import cs_pkg::*;
#(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned PERIOD      = 200,
    parameter int unsigned NOM_CODE    = 100,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap_i,
    input  logic              line_i,
    output logic [CODE_W-1:0] bus_code_o
);
    localparam int unsigned MAXC = (1 << CODE_W) - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       acc_q;
    logic [CODE_W-1:0]      bus_q;
    logic                   low_s;

    assign low_s = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            acc_q  <= '0;
            bus_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (wrap_i) begin
                acc_q <= '0;
                bus_q <= CODE_W'(len_to_code(32'(acc_q) + 32'(low_s),
                                             PERIOD, NOM_CODE, MAXC));
            end else begin
                acc_q <= acc_q + CNT_W'(low_s);
            end
        end
    end

    assign bus_code_o = bus_q;

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(acc_q) < PERIOD); // R5
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wrap_i) |-> $stable(bus_code_o)); // R5

endmodule

// File: rtl/cs_share_err.sv
module cs_share_err
    import cs_pkg::*;
#(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned ERR_W    = 6,
    parameter int unsigned NOM_CODE = 100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CODE_W-1:0]       bus_i,
    input  logic [CODE_W-1:0]       loc_i,
    output logic signed [ERR_W-1:0] err_o
);
    localparam int DW = CODE_W + 2;
    localparam logic [CODE_W-1:0] MIN_CODE = CODE_W'(NOM_CODE * MIN_PCT / 100);
    localparam logic signed [DW-1:0] EMAX = DW'((1 << (ERR_W - 1)) - 1);
    localparam logic signed [DW-1:0] EMIN = -EMAX - DW'(1);

    logic signed [DW-1:0]    diff;
    logic signed [ERR_W-1:0] err_d;
    logic signed [ERR_W-1:0] err_q;

    always_comb begin
        diff = $signed({2'b00, bus_i}) - $signed({2'b00, loc_i});
        if (loc_i < MIN_CODE)  err_d = '0;
        else if (diff > EMAX)  err_d = ERR_W'(EMAX);
        else if (diff < EMIN)  err_d = ERR_W'(EMIN);
        else                   err_d = ERR_W'(diff);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= err_d;
    end

    assign err_o = err_q;

    AST_LOW_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (loc_i < MIN_CODE) |=> (err_o == '0)); // R7
    AST_ERR_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        (loc_i >= MIN_CODE && bus_i > loc_i) |=> (!err_o[ERR_W-1] && err_o != '0)); // R6
    AST_ERR_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
        (loc_i >= MIN_CODE && bus_i < loc_i) |=> err_o[ERR_W-1]); // R6

endmodule

// File: rtl/duty_share_top.sv
module duty_share_top #(
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned PERIOD      = 200,
    parameter int unsigned NOM_CODE    = 100,
    parameter int unsigned ERR_W       = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CODE_W-1:0]       cur_code_i,
    input  logic                    cs_line_i,
    output logic                    cs_pull_o,
    output logic [CODE_W-1:0]       bus_code_o,
    output logic signed [ERR_W-1:0] share_err_o
);
    localparam int unsigned CNT_W = $clog2(PERIOD + 1);

    logic [CNT_W-1:0]  phase;
    logic              wrap;
    logic [CODE_W-1:0] loc_code;
    logic [CODE_W-1:0] bus_code;

    cs_phase_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .phase_o(phase), .wrap_o(wrap)
    );

    cs_duty_enc #(.CODE_W(CODE_W), .PERIOD(PERIOD), .NOM_CODE(NOM_CODE),
                  .CNT_W(CNT_W)) enc_i (
        .clk(clk), .rst(rst), .wrap_i(wrap), .phase_i(phase),
        .code_i(cur_code_i), .code_o(loc_code), .pull_o(cs_pull_o)
    );

    cs_bus_dec #(.CODE_W(CODE_W), .PERIOD(PERIOD), .NOM_CODE(NOM_CODE),
                 .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) dec_i (
        .clk(clk), .rst(rst), .wrap_i(wrap), .line_i(cs_line_i),
        .bus_code_o(bus_code)
    );

    cs_share_err #(.CODE_W(CODE_W), .ERR_W(ERR_W), .NOM_CODE(NOM_CODE)) err_i (
        .clk(clk), .rst(rst), .bus_i(bus_code), .loc_i(loc_code),
        .err_o(share_err_o)
    );

    assign bus_code_o = bus_code;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!cs_pull_o && bus_code_o == '0 && share_err_o == '0)); // R1

endmodule

// File: tb/duty_share_top_tb_top.sv
module duty_share_top_tb_top;
    localparam int P   = 200;
    localparam int NOM = 100;
    localparam int CW  = 8;
    localparam int EW  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cur_code = '0;
    logic cs_line;
    logic cs_pull;
    logic [CW-1:0] bus_code;
    logic signed [EW-1:0] share_err;

    int ext_cnt = 0;
    int ext_len = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        int    bus;
        int    err;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    assign cs_line = !(cs_pull || (ext_cnt < ext_len));

    duty_share_top #(.CODE_W(CW), .PERIOD(P), .NOM_CODE(NOM), .ERR_W(EW)) dut_i (
        .clk(clk), .rst(rst), .cur_code_i(cur_code), .cs_line_i(cs_line),
        .cs_pull_o(cs_pull), .bus_code_o(bus_code), .share_err_o(share_err)
    );

    // Second unit on the line, aligned to the same period start.
    initial begin
        forever begin
            @(posedge clk);
            if (rst) ext_cnt <= 0;
            else     ext_cnt <= (ext_cnt == P - 1) ? 0 : ext_cnt + 1;
        end
    end

    function automatic int exp_len(int code);
        int t;
        t = code * P * 65 / (100 * NOM);
        return (t > P) ? P : t;
    endfunction

    function automatic int exp_bus(int cnt);
        int c;
        c = cnt * 100 * NOM / (65 * P);
        return (c > 255) ? 255 : c;
    endfunction

    function automatic int exp_err(int bus, int loc);
        int d;
        if (loc < NOM * 20 / 100) return 0;
        d = bus - loc;
        if (d > 31)  return 31;
        if (d < -32) return -32;
        return d;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply stimulus, settle, measure the pulse, queue expectations.
    task automatic run_case(string tag, int code, int ext);
        int width;
        int cnt;
        @(negedge clk);
        cur_code = CW'(code);
        ext_len  = ext;
        repeat (3 * P) @(negedge clk);
        width = 0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (cs_pull) width++;
        end
        check({tag, " R2 pulse width"}, width, exp_len(code));
        cnt = (exp_len(code) > ext) ? exp_len(code) : ext;
        sb_q.push_back('{tag, exp_bus(cnt), exp_err(exp_bus(cnt), code)});
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop expectations and compare the live outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R5 bus code"}, int'(bus_code), e.bus);
                check({e.tag, " R6 share error"}, int'(share_err), e.err);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 pull in reset", int'(cs_pull), 0);
        check("R1 bus code in reset", int'(bus_code), 0);
        check("R1 error in reset", int'(share_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pull after reset", int'(cs_pull), 0);

        run_case("R3 nominal", 100, 0);     // 130 clocks, bus 100, err 0
        run_case("R2 partial", 37, 0);      // 48 clocks, bus 36, err -1
        run_case("R4 clamp", 255, 0);       // 200 clocks, bus 153, err sat -32
        run_case("R6 sat high", 50, 117);   // bus 90, err sat 31
        run_case("R7 below min", 19, 39);   // bus 30, err gated 0
        run_case("R7 at min", 20, 39);      // bus 30, err 10
        run_case("R3 zero", 0, 0);          // no pulse, bus 0, err 0
        run_case("R5 wired max", 30, 130);  // bus 100, err sat 31
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
                repeat (3) @(negedge clk);
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule